// File: doc/BRIEF.md
# Bi-Phase-Mark PRBS Loopback Link Tester

The block drives a serial line with a bi-phase-mark (BPM) signal carrying a PRBS-7 payload, and measures the bit error rate of whatever path brings the decoded data back. The line changes level at the start of every bit. A logic one adds a second change in the middle of the bit. After a start pulse the transmitter first sends a run of zeros whose length is programmable. This gives a far-end decoder time to lock before the payload begins.

The checker does not need to know the loop latency. It waits for the first one to come back, builds its predictor from seven received bits, and then compares every later bit with its own free-running PRBS prediction. It counts compared bits and mismatches in saturating 40-bit counters. If a 64-bit window collects too many mismatches, the checker drops lock and seeds itself again from the incoming data.

Timing comes from a half-bit strobe. Two strobes make one bit: the first strobe opens the bit and the second marks its middle. Returned data arrives as one NRZ bit per cycle in which `rx_valid` is high.

Top module: `bpm_prbs_tester`

## Requirements
- R1: After reset, `line_out` is 0, `locked` is 0, and both counters are 0.
- R2: Until the first `start` pulse, `half_stb` has no effect and `line_out` stays constant.
- R3: Once started, `line_out` inverts on the first half-strobe of every bit. Half-strobes alternate: first half, then second half, and the first strobe after `start` is a first half.
- R4: On the second half-strobe of a bit, `line_out` inverts again when the bit is 1 and holds when it is 0.
- R5: After `start`, the first `train_len` bits are zeros. `train_len` is sampled in the start cycle, and a value of 0 means the payload begins at once.
- R6: Payload bits follow PRBS-7 (x^7+x^6+1). `start` loads the 7-bit state s with SEED (default 7'h5A). Each payload bit b equals s[6] xor s[5], and the state then becomes {s[5:0], b}.
- R7: While unlocked, the checker neither compares nor counts. It locks on the seventh received bit, counting from the first 1 it sees after `start` or after losing lock. From then on, each bit is compared with the prediction p[6] xor p[5], and p advances as {p[5:0], prediction}.
- R8: While locked, every `rx_valid` bit adds 1 to `bit_cnt`, and every mismatch adds 1 to `err_cnt`.
- R9: Compared bits are grouped in windows of 64 that begin at the moment of lock. The 8th mismatch within one window is counted, and it clears `locked` in the same cycle, after which R7 applies again. Seven mismatches in a window keep the lock.
- R10: Both counters are CNT_W bits wide (default 40, which holds more than 4x10^8). Each one stops at all-ones and never wraps.
- R11: A `start` pulse clears both counters and the lock, and restarts training (R5) and the PRBS (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a measurement |
| train_len | input | TRAIN_W | Number of zero bits sent before the payload |
| half_stb | input | 1 | Half-bit timing strobe |
| line_out | output | 1 | BPM-encoded serial line |
| rx_data | input | 1 | Returned NRZ data bit |
| rx_valid | input | 1 | Marks a valid `rx_data` bit |
| locked | output | 1 | Checker is locked to the returned sequence |
| err_cnt | output | CNT_W | Mismatched compared bits |
| bit_cnt | output | CNT_W | Total compared bits |

## Verification
Internal faults show up at the ports in different ways:
- A wrong half-strobe phase or a stuck training counter breaks the BPM pattern. The decoded line then differs from the reference within the first bit or two after `start`.
- A wrong checker seed or wrong lock timing makes `locked` rise one bit early or late. It can also fill `err_cnt` within a few bits, because a bad predictor mismatches about half the time.
- A window counter or threshold that is off by one separates the seven-error case from the eight-error case on the very bit that ends a burst.
- Broken saturation shows on a narrow-counter instance as a wrap to zero a single bit after full scale.

// File: rtl/bpm_prbs_tester.sv
module bpm_prbs_tester #(
  parameter int TRAIN_W   = 16,
  parameter int CNT_W     = 40,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 8,
  parameter logic [6:0] SEED = 7'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TRAIN_W-1:0] train_len,
  input  logic               half_stb,
  output logic               line_out,
  input  logic               rx_data,
  input  logic               rx_valid,
  output logic               locked,
  output logic [CNT_W-1:0]   err_cnt,
  output logic [CNT_W-1:0]   bit_cnt
);
  localparam int WIN_W = $clog2(WIN);
  localparam int EW    = $clog2(ERR_LIMIT + 1);

  logic               run, phase, cur_bit;
  logic [TRAIN_W-1:0] train_left;
  logic [6:0]         prbs;
  logic               tx_nb;
  logic               in_train;

  assign tx_nb    = prbs[6] ^ prbs[5];
  assign in_train = (train_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      phase      <= 1'b0;
      cur_bit    <= 1'b0;
      train_left <= '0;
      prbs       <= SEED;
      line_out   <= 1'b0;
    end else if (start) begin
      run        <= 1'b1;
      phase      <= 1'b0;
      cur_bit    <= 1'b0;
      train_left <= train_len;
      prbs       <= SEED;
    end else if (run && half_stb) begin
      if (!phase) begin
        line_out <= ~line_out;
        phase    <= 1'b1;
        if (in_train) begin
          cur_bit    <= 1'b0;
          train_left <= train_left - 1'b1;
        end else begin
          cur_bit <= tx_nb;
          prbs    <= {prbs[5:0], tx_nb};
        end
      end else begin
        phase <= 1'b0;
        if (cur_bit) line_out <= ~line_out;
      end
    end
  end

  logic [6:0]       chk;
  logic [2:0]       fill;
  logic [WIN_W-1:0] win_cnt;
  logic [EW-1:0]    win_err;
  logic [6:0]       chk_nxt;
  logic             pred, mis, drop;

  assign chk_nxt = {chk[5:0], rx_data};
  assign pred    = chk[6] ^ chk[5];
  assign mis     = rx_data ^ pred;
  assign drop    = (32'(win_err) + 32'(mis)) >= ERR_LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk     <= '0;
      fill    <= '0;
      locked  <= 1'b0;
      win_cnt <= '0;
      win_err <= '0;
      err_cnt <= '0;
      bit_cnt <= '0;
    end else if (start) begin
      chk     <= '0;
      fill    <= '0;
      locked  <= 1'b0;
      win_cnt <= '0;
      win_err <= '0;
      err_cnt <= '0;
      bit_cnt <= '0;
    end else if (rx_valid) begin
      if (!locked) begin
        chk <= chk_nxt;
        if (chk_nxt == '0) fill <= '0;
        else if (fill == 3'd6) begin
          locked  <= 1'b1;
          fill    <= '0;
          win_cnt <= '0;
          win_err <= '0;
        end else fill <= fill + 1'b1;
      end else begin
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        if (mis && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
        if (drop) begin
          locked <= 1'b0;
          chk    <= '0;
          fill   <= '0;
        end else begin
          chk <= {chk[5:0], pred};
          if (win_cnt == WIN_W'(WIN - 1)) begin
            win_cnt <= '0;
            win_err <= '0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
            win_err <= win_err + EW'(mis);
          end
        end
      end
    end
  end

  // R3
  bit_start_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_stb && !phase && !start) |=> (line_out != $past(line_out)));

  // R5
  train_no_mid_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_stb && phase && !cur_bit && !start) |=> $stable(line_out));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(line_out));

  // R10
  bits_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (bit_cnt >= $past(bit_cnt)));

  // R8
  err_within_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= bit_cnt);

  // R7
  no_count_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !start) |=> $stable(bit_cnt));
endmodule

// File: tb/bpm_prbs_tester_tb.sv
module bpm_prbs_tester_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, start = 0, half_stb = 0, rx_data = 0, rx_valid = 0;
  logic [15:0] train_len = '0;
  logic line_out, locked, sat_line, sat_locked;
  logic [39:0] err_cnt, bit_cnt;
  logic [5:0]  sat_err, sat_bits;

  int checks = 0, failures = 0;
  int strm[512];
  int s_idx, fed;
  logic prev_line;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bpm_prbs_tester u_dut (.clk, .rst_n, .start, .train_len, .half_stb, .line_out,
    .rx_data, .rx_valid, .locked, .err_cnt, .bit_cnt);

  bpm_prbs_tester #(.CNT_W(6)) u_sat (.clk, .rst_n, .start, .train_len, .half_stb,
    .line_out(sat_line), .rx_data, .rx_valid, .locked(sat_locked),
    .err_cnt(sat_err), .bit_cnt(sat_bits));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input int lat, input int tl);
    logic [6:0] s = 7'h5A;
    for (int i = 0; i < 512; i++) begin
      if (i < lat + tl) strm[i] = 0;
      else begin
        logic b = s[6] ^ s[5];
        strm[i] = int'(b);
        s = {s[5:0], b};
      end
    end
    s_idx = -1;
    for (int i = 0; i < 512; i++)
      if (s_idx < 0 && strm[i] == 1) s_idx = i + 7;
    fed = 0;
  endtask

  task automatic pulse_start(input int tl);
    @(negedge clk); train_len = 16'(tl); start = 1;
    @(negedge clk); start = 0;
    prev_line = line_out;
  endtask

  task automatic half_step();
    @(negedge clk); half_stb = 1;
    @(negedge clk); half_stb = 0;
  endtask

  task automatic decode_bit(output int b, input string req);
    logic l0;
    half_step(); l0 = line_out;
    chk(l0 != prev_line, "R3 toggle at bit start", longint'(l0), longint'(~prev_line));
    half_step();
    b = int'(l0 ^ line_out);
    prev_line = line_out;
  endtask

  task automatic feed_to(input int last, input int flo, input int fhi);
    while (fed <= last) begin
      int b = strm[fed];
      if (fed >= s_idx + flo && fed <= s_idx + fhi) b = 1 - b;
      @(negedge clk); rx_data = b[0]; rx_valid = 1;
      @(negedge clk); rx_valid = 0;
      fed++;
    end
  endtask

  task automatic t_reset();
    chk(line_out == 0, "R1 line", longint'(line_out), 0);
    chk(locked == 0, "R1 locked", longint'(locked), 0);
    chk(err_cnt == 0 && bit_cnt == 0, "R1 counters", longint'(err_cnt + bit_cnt), 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 6; i++) half_step();
    chk(line_out == 0, "R2 idle line", longint'(line_out), 0);
  endtask

  task automatic t_tx();
    int b, bad;
    build(0, 5);
    pulse_start(5);
    bad = 0;
    for (int i = 0; i < 5; i++) begin decode_bit(b, "R5"); if (b != 0) bad++; end
    chk(bad == 0, "R5 training zeros", bad, 0);
    bad = 0;
    for (int i = 5; i < 45; i++) begin decode_bit(b, "R6"); if (b != strm[i]) bad++; end
    chk(bad == 0, "R4 R6 payload bits", bad, 0);
    build(0, 0);
    pulse_start(0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin decode_bit(b, "R5"); if (b != strm[i]) bad++; end
    chk(bad == 0, "R5 zero training", bad, 0);
  endtask

  task automatic t_lock();
    build(3, 4);
    pulse_start(4);
    feed_to(s_idx - 2, 1, 0);
    chk(locked == 0, "R7 not yet locked", longint'(locked), 0);
    feed_to(s_idx - 1, 1, 0);
    chk(locked == 1, "R7 lock on 7th bit", longint'(locked), 1);
    chk(bit_cnt == 0, "R7 lock bits not counted", longint'(bit_cnt), 0);
    feed_to(s_idx + 49, 1, 0);
    chk(bit_cnt == 50, "R8 bit count", longint'(bit_cnt), 50);
    chk(err_cnt == 0, "R8 clean errors", longint'(err_cnt), 0);
    feed_to(s_idx + 60, 60, 60);
    feed_to(s_idx + 119, 100, 100);
    chk(err_cnt == 2, "R8 single errors", longint'(err_cnt), 2);
    chk(bit_cnt == 120, "R8 bit count after errors", longint'(bit_cnt), 120);
    chk(locked == 1, "R9 stays locked", longint'(locked), 1);
  endtask

  task automatic t_seven();
    build(0, 3);
    pulse_start(3);
    feed_to(s_idx + 30, 0, 6);
    chk(locked == 1, "R9 seven errors keep lock", longint'(locked), 1);
    chk(err_cnt == 7, "R9 seven counted", longint'(err_cnt), 7);
  endtask

  task automatic t_burst();
    build(0, 3);
    pulse_start(3);
    feed_to(s_idx + 16, 10, 17);
    chk(locked == 1, "R9 seventh in burst", longint'(locked), 1);
    feed_to(s_idx + 17, 10, 17);
    chk(locked == 0, "R9 eighth error drops lock", longint'(locked), 0);
    chk(err_cnt == 8, "R9 eighth counted", longint'(err_cnt), 8);
    feed_to(s_idx + 47, 1, 0);
    chk(locked == 1, "R9 relock", longint'(locked), 1);
    chk(err_cnt == 8, "R9 clean after relock", longint'(err_cnt), 8);
  endtask

  task automatic t_clear();
    pulse_start(2);
    chk(err_cnt == 0 && bit_cnt == 0, "R11 counters cleared", longint'(err_cnt + bit_cnt), 0);
    chk(locked == 0, "R11 lock cleared", longint'(locked), 0);
  endtask

  task automatic t_sat();
    build(0, 2);
    pulse_start(2);
    feed_to(s_idx + 99, 1, 0);
    chk(sat_bits == 6'h3F, "R10 saturate", longint'(sat_bits), 63);
    chk(bit_cnt == 100, "R10 wide counter", longint'(bit_cnt), 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_tx();
    t_lock();
    t_seven();
    t_burst();
    t_clear();
    t_sat();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule